// File: doc/BRIEF.md
# DRAM Frequency-Change Sequencer

This block is a hardware state machine that carries a DRAM controller through a change of operating point (P-state) without software stepping through the procedure. A single start request begins the sequence. The block first closes the host ports and waits for them to go quiet. It then stops the host command interface and waits for the command queues to drain. Next it places the memory in self-refresh, publishes the new P-state and flips the refresh-update level. Around the clock switch it runs an init handshake with the PHY. After a programmable guard delay it leaves self-refresh. It then replays the mode registers of every rank through a mode-register-write port and finally reopens traffic.

Each step after the start is a plain level wait on one status input. The controller, PHY and clock generator sit outside the block and answer through those inputs. The block has no data stream. Every pin is either a control level or a status level. The only handshake is on the mode-register-write port: a request is held until the done input is sampled high.

A programmable timeout watches every wait. A wait that stays unmet for too long raises a sticky error flag. The sequence does not abandon the memory in an unknown state, so it keeps waiting after the flag rises.

Top module: `fchg_seq`

## Requirements
- R1: In reset and immediately after it, the outputs are: cfg_done_o=1, port_en_o=1, hif_dis_o=0, sr_req_o=0, pstate_o=0, refresh_lvl_o=0, init_start_o=0, clk_sw_req_o=0, mrw_req_o=0, done_o=0 and err_o=0.
- R2: When idle, start_i sampled high latches pstate_i and rank_cnt_i, and cfg_done_o and port_en_o fall at that edge. The block then waits until rd_busy_i and wr_busy_i are both sampled low. At that edge hif_dis_o rises.
- R3: With hif_dis_o high, the block waits until wq_empty_i and rq_empty_i are both sampled high. At that edge sr_req_o rises.
- R4: The block waits until all six bits of op_mode_i equal 0x23; a code such as 0x03 does not satisfy the wait. At that edge three things happen together: pstate_o takes the latched P-state, refresh_lvl_o inverts, and init_start_o rises.
- R5: After init_done_i is sampled low, clk_sw_req_o rises. When clk_sw_done_i is sampled high, clk_sw_req_o and init_start_o fall together. The block then waits for init_done_i high.
- R6: After init_done_i returns high, the block stays in a guard delay for guard_cyc_i cycles (at least one). At the end of the delay sr_req_o falls. It then waits until op_mode_i differs from 0x23.
- R7: For each rank from 1 to the latched rank count (a count of 0 acts as 1), the block issues seven mode-register writes in order. Indices 0 to 5 carry table words 0 to 5. Index 6 carries table word 7; word 6 is never sent. Table word k sits at mr_tab_i[16k+15:16k]. mrw_req_o stays high with mrw_rank_o, mrw_idx_o and mrw_data_o stable until mrw_done_i is sampled high. The next write is presented in the following cycle.
- R8: After the last write is accepted, hif_dis_o falls while port_en_o and cfg_done_o rise, all at the same edge. The block then waits for cfg_ack_i high. done_o then pulses for exactly one cycle, and the block returns to idle.
- R9: If any wait stays unmet for timeout_cyc_i consecutive sampled cycles, err_o rises at the edge of the last of those cycles. err_o stays high, the wait continues, and err_o clears only when the next start is accepted.
- R10: A start_i pulse while a sequence runs is ignored. The P-state and rank count latched at the accepted start are the ones used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a frequency change |
| pstate_i | input | PS_W | Target P-state |
| rank_cnt_i | input | RANK_W | Number of ranks to reprogram |
| guard_cyc_i | input | GUARD_W | Guard delay in cycles before leaving self-refresh |
| timeout_cyc_i | input | TO_W | Cycle limit for any single wait |
| mr_tab_i | input | 8*MR_W | Mode-register table for the target P-state, word k at bits 16k+15:16k |
| rd_busy_i | input | 1 | Read port busy |
| wr_busy_i | input | 1 | Write port busy |
| wq_empty_i | input | 1 | Write queue empty |
| rq_empty_i | input | 1 | Read queue empty |
| op_mode_i | input | 6 | Controller operating status code |
| init_done_i | input | 1 | PHY init complete |
| clk_sw_done_i | input | 1 | Clock switch finished |
| mrw_done_i | input | 1 | Mode-register write accepted |
| cfg_ack_i | input | 1 | Acknowledge of the programming-done flag |
| cfg_done_o | output | 1 | Quasi-dynamic programming done flag |
| port_en_o | output | 1 | Host port enable |
| hif_dis_o | output | 1 | Host command interface disable |
| sr_req_o | output | 1 | Self-refresh request |
| pstate_o | output | PS_W | Published P-state |
| refresh_lvl_o | output | 1 | Refresh-update level |
| init_start_o | output | 1 | PHY init start |
| clk_sw_req_o | output | 1 | Clock switch request |
| mrw_req_o | output | 1 | Mode-register write request |
| mrw_rank_o | output | RANK_W | Rank of the current write (1-based) |
| mrw_idx_o | output | 3 | Mode-register index of the current write |
| mrw_data_o | output | MR_W | Data of the current write |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky wait-timeout flag |

## Verification
Every control output moves at the first rising edge where its wait condition is sampled true. The bench therefore expects each strobe one clock after the enabling status value is seen. The guard delay adds guard_cyc_i edges before sr_req_o falls. done_o follows cfg_ack_i by one edge, and err_o rises on the edge of the timeout_cyc_i-th unmet sample. A behavioural reference in the bench advances on each rising edge from the same inputs. All outputs are compared with it at the falling edge, after every register has settled. The bench's own models of the controller and PHY change the status inputs only at falling edges, with adjustable latencies and stalls.

// File: rtl/fchg_pkg.sv
package fchg_pkg;

  localparam int MR_ENTRIES = 8;
  localparam logic [2:0] MR_LAST_IDX = 3'd6;
  localparam logic [2:0] MR_LAST_ENTRY = 3'd7;
  localparam logic [5:0] SR_CODE = 6'h23;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PORT,
    ST_QUEUE,
    ST_SR_IN,
    ST_INIT_LO,
    ST_CLK,
    ST_INIT_HI,
    ST_GUARD,
    ST_SR_OUT,
    ST_MRW,
    ST_ACK
  } seq_state_e;

endpackage

// File: rtl/fchg_wait_timer.sv
module fchg_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stall_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         err_o
);

  logic [W-1:0] cnt_q;
  logic [W:0]   seen;
  logic         err_q;

  // number of consecutive unmet samples including the current one
  assign seen = {1'b0, cnt_q} + (W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (!stall_i) begin
        cnt_q <= '0;
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + W'(1);
      end
      if (clr_i) begin
        err_q <= 1'b0;
      end else if (stall_i && (seen >= {1'b0, limit_i})) begin
        err_q <= 1'b1;
      end
    end
  end

  assign err_o = err_q;

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_i) |=> err_q);

  assert_err_needs_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(stall_i));

endmodule

// File: rtl/fchg_guard_timer.sv
module fchg_guard_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         en_i,
  input  logic [W-1:0] val_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (en_i && (cnt_q > W'(1))) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expire_o = (cnt_q <= W'(1));

  assert_guard_descends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !load_i && !expire_o) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/fchg_mr_walker.sv
module fchg_mr_walker
  import fchg_pkg::*;
#(
  parameter int RANK_W = 2,
  parameter int MR_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic                     step_i,
  input  logic [RANK_W-1:0]        rank_cnt_i,
  input  logic [MR_ENTRIES*MR_W-1:0] tab_i,
  output logic [RANK_W-1:0]        rank_o,
  output logic [2:0]               idx_o,
  output logic [MR_W-1:0]          data_o,
  output logic                     last_o
);

  logic [MR_W-1:0]   word [MR_ENTRIES];
  logic [RANK_W-1:0] rank_q;
  logic [2:0]        idx_q;
  logic [2:0]        sel;

  for (genvar g = 0; g < MR_ENTRIES; g++) begin : g_unpack
    assign word[g] = tab_i[g*MR_W +: MR_W];
  end

  // the final index of each rank is fed from the spare top table slot
  assign sel    = (idx_q == MR_LAST_IDX) ? MR_LAST_ENTRY : idx_q;
  assign data_o = word[sel];
  assign last_o = (idx_q == MR_LAST_IDX) && (rank_q >= rank_cnt_i);
  assign rank_o = rank_q;
  assign idx_o  = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      rank_q <= RANK_W'(1);
      idx_q  <= '0;
    end else if (step_i) begin
      if (idx_q == MR_LAST_IDX) begin
        idx_q  <= '0;
        rank_q <= rank_q + RANK_W'(1);
      end else begin
        idx_q <= idx_q + 3'd1;
      end
    end
  end

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= MR_LAST_IDX);

endmodule

// File: rtl/fchg_seq.sv
module fchg_seq
  import fchg_pkg::*;
#(
  parameter int PS_W    = 2,
  parameter int RANK_W  = 2,
  parameter int MR_W    = 16,
  parameter int GUARD_W = 16,
  parameter int TO_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [PS_W-1:0]            pstate_i,
  input  logic [RANK_W-1:0]          rank_cnt_i,
  input  logic [GUARD_W-1:0]         guard_cyc_i,
  input  logic [TO_W-1:0]            timeout_cyc_i,
  input  logic [MR_ENTRIES*MR_W-1:0] mr_tab_i,
  input  logic                       rd_busy_i,
  input  logic                       wr_busy_i,
  input  logic                       wq_empty_i,
  input  logic                       rq_empty_i,
  input  logic [5:0]                 op_mode_i,
  input  logic                       init_done_i,
  input  logic                       clk_sw_done_i,
  input  logic                       mrw_done_i,
  input  logic                       cfg_ack_i,
  output logic                       cfg_done_o,
  output logic                       port_en_o,
  output logic                       hif_dis_o,
  output logic                       sr_req_o,
  output logic [PS_W-1:0]            pstate_o,
  output logic                       refresh_lvl_o,
  output logic                       init_start_o,
  output logic                       clk_sw_req_o,
  output logic                       mrw_req_o,
  output logic [RANK_W-1:0]          mrw_rank_o,
  output logic [2:0]                 mrw_idx_o,
  output logic [MR_W-1:0]            mrw_data_o,
  output logic                       done_o,
  output logic                       err_o
);

  seq_state_e        state_q;
  logic [PS_W-1:0]   ps_lat_q;
  logic [RANK_W-1:0] rank_lat_q;
  logic              cfg_done_q, port_en_q, hif_dis_q, sr_req_q;
  logic [PS_W-1:0]   pstate_q;
  logic              rfl_q, init_q, clk_req_q, done_q;

  logic met, waiting, stall, start_acc;
  logic guard_load, guard_exp;
  logic walk_load, walk_step, walk_last;

  // wait condition of the current state
  always_comb begin
    unique case (state_q)
      ST_PORT:    met = !rd_busy_i && !wr_busy_i;
      ST_QUEUE:   met = wq_empty_i && rq_empty_i;
      ST_SR_IN:   met = (op_mode_i == SR_CODE);
      ST_INIT_LO: met = !init_done_i;
      ST_CLK:     met = clk_sw_done_i;
      ST_INIT_HI: met = init_done_i;
      ST_SR_OUT:  met = (op_mode_i != SR_CODE);
      ST_MRW:     met = mrw_done_i;
      ST_ACK:     met = cfg_ack_i;
      default:    met = 1'b0;
    endcase
  end

  assign waiting    = (state_q != ST_IDLE) && (state_q != ST_GUARD);
  assign stall      = waiting && !met;
  assign start_acc  = (state_q == ST_IDLE) && start_i;
  assign guard_load = (state_q == ST_INIT_HI) && met;
  assign walk_load  = (state_q == ST_SR_OUT) && met;
  assign walk_step  = (state_q == ST_MRW) && met;

  fchg_wait_timer #(.W(TO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall_i (stall),
    .clr_i   (start_acc),
    .limit_i (timeout_cyc_i),
    .err_o   (err_o)
  );

  fchg_guard_timer #(.W(GUARD_W)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (guard_load),
    .en_i     (state_q == ST_GUARD),
    .val_i    (guard_cyc_i),
    .expire_o (guard_exp)
  );

  fchg_mr_walker #(.RANK_W(RANK_W), .MR_W(MR_W)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (walk_load),
    .step_i     (walk_step),
    .rank_cnt_i (rank_lat_q),
    .tab_i      (mr_tab_i),
    .rank_o     (mrw_rank_o),
    .idx_o      (mrw_idx_o),
    .data_o     (mrw_data_o),
    .last_o     (walk_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ps_lat_q   <= '0;
      rank_lat_q <= '0;
      cfg_done_q <= 1'b1;
      port_en_q  <= 1'b1;
      hif_dis_q  <= 1'b0;
      sr_req_q   <= 1'b0;
      pstate_q   <= '0;
      rfl_q      <= 1'b0;
      init_q     <= 1'b0;
      clk_req_q  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ps_lat_q   <= pstate_i;
          rank_lat_q <= rank_cnt_i;
          cfg_done_q <= 1'b0;
          port_en_q  <= 1'b0;
          state_q    <= ST_PORT;
        end
        ST_PORT: if (met) begin
          hif_dis_q <= 1'b1;
          state_q   <= ST_QUEUE;
        end
        ST_QUEUE: if (met) begin
          sr_req_q <= 1'b1;
          state_q  <= ST_SR_IN;
        end
        ST_SR_IN: if (met) begin
          pstate_q <= ps_lat_q;
          rfl_q    <= ~rfl_q;
          init_q   <= 1'b1;
          state_q  <= ST_INIT_LO;
        end
        ST_INIT_LO: if (met) begin
          clk_req_q <= 1'b1;
          state_q   <= ST_CLK;
        end
        ST_CLK: if (met) begin
          clk_req_q <= 1'b0;
          init_q    <= 1'b0;
          state_q   <= ST_INIT_HI;
        end
        ST_INIT_HI: if (met) begin
          state_q <= ST_GUARD;
        end
        ST_GUARD: if (guard_exp) begin
          sr_req_q <= 1'b0;
          state_q  <= ST_SR_OUT;
        end
        ST_SR_OUT: if (met) begin
          state_q <= ST_MRW;
        end
        ST_MRW: if (met && walk_last) begin
          hif_dis_q  <= 1'b0;
          port_en_q  <= 1'b1;
          cfg_done_q <= 1'b1;
          state_q    <= ST_ACK;
        end
        ST_ACK: if (met) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_done_o    = cfg_done_q;
  assign port_en_o     = port_en_q;
  assign hif_dis_o     = hif_dis_q;
  assign sr_req_o      = sr_req_q;
  assign pstate_o      = pstate_q;
  assign refresh_lvl_o = rfl_q;
  assign init_start_o  = init_q;
  assign clk_sw_req_o  = clk_req_q;
  assign mrw_req_o     = (state_q == ST_MRW);
  assign done_o        = done_q;

  assert_port_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hif_dis_q) |-> (!port_en_q && $past(!rd_busy_i) && $past(!wr_busy_i)));

  assert_sr_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_req_q) |-> (hif_dis_q && $past(wq_empty_i) && $past(rq_empty_i)));

  assert_init_in_sr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_q) |-> (sr_req_q && ($past(op_mode_i) == SR_CODE)));

  assert_clk_inside_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_req_q |-> init_q);

  assert_sr_exit_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_req_q) |-> (!init_q && !clk_req_q && hif_dis_q));

  assert_mrw_out_of_sr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mrw_req_o |-> (!sr_req_q && hif_dis_q && !port_en_q));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(ps_lat_q) && $stable(rank_lat_q)));

endmodule

// File: tb/fchg_seq_bench.sv
module fchg_seq_bench;
  import fchg_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int PS_W = 2, RANK_W = 2, MR_W = 16, GUARD_W = 16, TO_W = 16;
  localparam int P_IDLE = 0, P_PORT = 1, P_QUEUE = 2, P_SRIN = 3, P_ILO = 4,
                 P_CLK = 5, P_IHI = 6, P_GUARD = 7, P_SROUT = 8, P_MRW = 9, P_ACK = 10;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [PS_W-1:0] pstate_i = '0;
  logic [RANK_W-1:0] rank_cnt_i = '0;
  logic [GUARD_W-1:0] guard_cyc_i = 16'd3;
  logic [TO_W-1:0] timeout_cyc_i = 16'd60;
  logic [8*MR_W-1:0] mr_tab_i = '0;
  logic rd_busy_i, wr_busy_i, wq_empty_i, rq_empty_i, init_done_i, clk_sw_done_i, cfg_ack_i;
  logic mrw_done_i = 1'b0;
  logic [5:0] op_mode_i;
  logic cfg_done_o, port_en_o, hif_dis_o, sr_req_o, refresh_lvl_o, init_start_o, clk_sw_req_o;
  logic mrw_req_o, done_o, err_o;
  logic [PS_W-1:0] pstate_o;
  logic [RANK_W-1:0] mrw_rank_o;
  logic [2:0] mrw_idx_o;
  logic [MR_W-1:0] mrw_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  fchg_seq u_fchg_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pstate_i(pstate_i), .rank_cnt_i(rank_cnt_i),
    .guard_cyc_i(guard_cyc_i), .timeout_cyc_i(timeout_cyc_i), .mr_tab_i(mr_tab_i),
    .rd_busy_i(rd_busy_i), .wr_busy_i(wr_busy_i), .wq_empty_i(wq_empty_i), .rq_empty_i(rq_empty_i),
    .op_mode_i(op_mode_i), .init_done_i(init_done_i), .clk_sw_done_i(clk_sw_done_i),
    .mrw_done_i(mrw_done_i), .cfg_ack_i(cfg_ack_i), .cfg_done_o(cfg_done_o), .port_en_o(port_en_o),
    .hif_dis_o(hif_dis_o), .sr_req_o(sr_req_o), .pstate_o(pstate_o), .refresh_lvl_o(refresh_lvl_o),
    .init_start_o(init_start_o), .clk_sw_req_o(clk_sw_req_o), .mrw_req_o(mrw_req_o),
    .mrw_rank_o(mrw_rank_o), .mrw_idx_o(mrw_idx_o), .mrw_data_o(mrw_data_o), .done_o(done_o), .err_o(err_o)
  );

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [MR_W-1:0] tab_word(int ps, int e);
    return MR_W'((ps + 1) * 4096 + e * 257);
  endfunction

  // environment: controller, PHY and clock generator with per-signal latency
  logic env_cur [8];
  logic env_tgt [8];
  int   env_lat [8];
  int   env_cnt [8];
  bit   env_frz [8];
  int   mr_lat = 1, mr_cnt = 0;
  logic [5:0] op_norm = 6'h01;
  int   run_ps = 0, w_rank = 1, w_idx = 0, w_count = 0;

  assign rd_busy_i     = env_cur[0];
  assign wr_busy_i     = env_cur[1];
  assign wq_empty_i    = env_cur[2];
  assign rq_empty_i    = env_cur[3];
  assign op_mode_i     = env_cur[4] ? SR_CODE : op_norm;
  assign init_done_i   = env_cur[5];
  assign clk_sw_done_i = env_cur[6];
  assign cfg_ack_i     = env_cur[7];

  // reference model state
  int m_ph = P_IDLE, m_stall = 0, m_g = 0, m_rank = 0, m_idx = 0, m_rlat = 0, m_pslat = 0, m_ps = 0;
  bit m_cfg = 1, m_port = 1, m_hif = 0, m_sr = 0, m_rfl = 0, m_init = 0, m_clk = 0, m_done = 0, m_err = 0;

  always @(posedge clk) begin : model
    bit met;
    if (!rst_n) begin
      m_ph = P_IDLE; m_stall = 0; m_cfg = 1; m_port = 1; m_hif = 0; m_sr = 0; m_ps = 0;
      m_rfl = 0; m_init = 0; m_clk = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0;
      case (m_ph)
        P_PORT:  met = !rd_busy_i && !wr_busy_i;
        P_QUEUE: met = wq_empty_i && rq_empty_i;
        P_SRIN:  met = (op_mode_i == 6'h23);
        P_ILO:   met = !init_done_i;
        P_CLK:   met = clk_sw_done_i;
        P_IHI:   met = init_done_i;
        P_SROUT: met = (op_mode_i != 6'h23);
        P_MRW:   met = mrw_done_i;
        P_ACK:   met = cfg_ack_i;
        default: met = 0;
      endcase
      if (m_ph != P_IDLE && m_ph != P_GUARD && !met) begin
        m_stall++;
        if (m_stall >= int'(timeout_cyc_i)) m_err = 1;
      end else m_stall = 0;
      case (m_ph)
        P_IDLE: if (start_i) begin
          m_err = 0; m_pslat = pstate_i; m_rlat = rank_cnt_i; m_cfg = 0; m_port = 0; m_ph = P_PORT;
        end
        P_PORT:  if (met) begin m_hif = 1; m_ph = P_QUEUE; end
        P_QUEUE: if (met) begin m_sr = 1; m_ph = P_SRIN; end
        P_SRIN:  if (met) begin m_ps = m_pslat; m_rfl = !m_rfl; m_init = 1; m_ph = P_ILO; end
        P_ILO:   if (met) begin m_clk = 1; m_ph = P_CLK; end
        P_CLK:   if (met) begin m_clk = 0; m_init = 0; m_ph = P_IHI; end
        P_IHI:   if (met) begin m_g = guard_cyc_i; m_ph = P_GUARD; end
        P_GUARD: if (m_g <= 1) begin m_sr = 0; m_ph = P_SROUT; end else m_g--;
        P_SROUT: if (met) begin m_rank = 1; m_idx = 0; m_ph = P_MRW; end
        P_MRW: if (met) begin
          if (m_idx == 6 && m_rank >= m_rlat) begin
            m_hif = 0; m_port = 1; m_cfg = 1; m_ph = P_ACK;
          end else if (m_idx == 6) begin m_idx = 0; m_rank++; end
          else m_idx++;
        end
        P_ACK: if (met) begin m_done = 1; m_ph = P_IDLE; end
        default: m_ph = P_IDLE;
      endcase
    end
  end

  // compare, then advance the environment, at every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8", "cfg_done_o", cfg_done_o, m_cfg);
      chk("R2", "port_en_o", port_en_o, m_port);
      chk("R3", "hif_dis_o", hif_dis_o, m_hif);
      chk("R6", "sr_req_o", sr_req_o, m_sr);
      chk("R4", "pstate_o", pstate_o, m_ps);
      chk("R4", "refresh_lvl_o", refresh_lvl_o, m_rfl);
      chk("R5", "init_start_o", init_start_o, m_init);
      chk("R5", "clk_sw_req_o", clk_sw_req_o, m_clk);
      chk("R7", "mrw_req_o", mrw_req_o, m_ph == P_MRW);
      chk("R8", "done_o", done_o, m_done);
      chk("R9", "err_o", err_o, m_err);
      if (m_ph == P_MRW) begin
        chk("R7", "mrw_rank_o", mrw_rank_o, m_rank);
        chk("R7", "mrw_idx_o", mrw_idx_o, m_idx);
        chk("R7", "mrw_data_o", mrw_data_o, tab_word(m_pslat, (m_idx == 6) ? 7 : m_idx));
      end
    end
    env_tgt[0] = port_en_o; env_tgt[1] = port_en_o;
    env_tgt[2] = hif_dis_o; env_tgt[3] = hif_dis_o;
    env_tgt[4] = sr_req_o;  env_tgt[5] = !init_start_o;
    env_tgt[6] = clk_sw_req_o; env_tgt[7] = cfg_done_o;
    for (int i = 0; i < 8; i++) begin
      if (env_frz[i] || env_cur[i] == env_tgt[i]) env_cnt[i] = 0;
      else if (env_cnt[i] >= env_lat[i]) begin env_cur[i] = env_tgt[i]; env_cnt[i] = 0; end
      else env_cnt[i]++;
    end
    if (mrw_req_o && !mrw_done_i) begin
      if (mr_cnt >= mr_lat) begin
        // independent tracking of the write order (R7)
        chk("R7", "write rank", mrw_rank_o, w_rank);
        chk("R7", "write idx", mrw_idx_o, w_idx);
        chk("R7", "write data", mrw_data_o, tab_word(run_ps, (w_idx == 6) ? 7 : w_idx));
        w_count++;
        if (w_idx == 6) begin w_idx = 0; w_rank++; end else w_idx++;
        mrw_done_i = 1'b1; mr_cnt = 0;
      end else mr_cnt++;
    end else mrw_done_i = 1'b0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_seq(int ps, int ranks, int guard, bit mid_start, bit stall_clk);
    bit seen_done = 0;
    bit rfl_before;
    int ranks_eff;
    @(negedge clk);
    rfl_before = refresh_lvl_o;
    run_ps = ps; w_rank = 1; w_idx = 0; w_count = 0;
    for (int e = 0; e < 8; e++) mr_tab_i[e*MR_W +: MR_W] = tab_word(ps, e);
    pstate_i = PS_W'(ps); rank_cnt_i = RANK_W'(ranks); guard_cyc_i = GUARD_W'(guard);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "port closed after start", port_en_o, 0);
    chk("R9", "err cleared by start", err_o, 0);
    if (mid_start) begin
      repeat (6) @(negedge clk);
      pstate_i = PS_W'(ps + 1); rank_cnt_i = RANK_W'(ranks + 1);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    if (stall_clk) begin
      env_frz[6] = 1;
      for (int k = 0; k < 2000 && !clk_sw_req_o; k++) @(negedge clk);
      repeat (int'(timeout_cyc_i) + 4) @(negedge clk);
      chk("R9", "err after stalled wait", err_o, 1);
      chk("R9", "still waiting on clock switch", clk_sw_req_o, 1);
      env_frz[6] = 0;
    end
    for (int k = 0; k < 5000 && !seen_done; k++) begin
      @(negedge clk);
      if (done_o) seen_done = 1;
    end
    chk("R8", "done pulse seen", seen_done, 1);
    @(negedge clk);
    chk("R8", "done is one cycle", done_o, 0);
    chk("R10", "pstate from accepted start", pstate_o, ps);
    chk("R4", "refresh level inverted", refresh_lvl_o, !rfl_before);
    ranks_eff = (ranks == 0) ? 1 : ranks;
    chk("R7", "write count", w_count, 7 * ranks_eff);
    chk("R8", "ports reopened", port_en_o, 1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin env_lat[i] = 2; env_cnt[i] = 0; env_frz[i] = 0; end
    env_cur[0] = 1; env_cur[1] = 1; env_cur[2] = 0; env_cur[3] = 0;
    env_cur[4] = 0; env_cur[5] = 1; env_cur[6] = 0; env_cur[7] = 1;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk("R1", "cfg_done_o", cfg_done_o, 1);
    chk("R1", "port_en_o", port_en_o, 1);
    chk("R1", "hif_dis_o", hif_dis_o, 0);
    chk("R1", "sr_req_o", sr_req_o, 0);
    chk("R1", "init_start_o", init_start_o, 0);
    chk("R1", "mrw_req_o", mrw_req_o, 0);
    chk("R1", "err_o", err_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset", {done_o, clk_sw_req_o, refresh_lvl_o, pstate_o}, 0);

    run_seq(2, 2, 5, 0, 0);
    // zero latencies, single rank, guard 0, start during the run (R10)
    for (int i = 0; i < 8; i++) env_lat[i] = 0;
    mr_lat = 0;
    run_seq(1, 1, 0, 1, 0);
    // uneven latencies, 0x03 outside self-refresh must not count as entry (R4)
    op_norm = 6'h03;
    env_lat[0] = 1; env_lat[1] = 4; env_lat[2] = 3; env_lat[3] = 0;
    env_lat[4] = 5; env_lat[5] = 2; env_lat[6] = 1; env_lat[7] = 3;
    mr_lat = 3;
    run_seq(3, 3, 9, 0, 0);
    // stalled clock switch raises the timeout flag (R9)
    timeout_cyc_i = 16'd20;
    run_seq(0, 2, 2, 0, 1);
    chk("R9", "err sticky after completion", err_o, 1);
    // rank count of zero acts as one; next start clears the flag
    timeout_cyc_i = 16'd60;
    op_norm = 6'h01;
    run_seq(2, 0, 1, 0, 0);
    chk("R9", "err clear on clean run", err_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule